// File: doc/BRIEF.md
# Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading translation tables from memory. A request carries the virtual address and a write flag. The walker first reads one entry from a context table, which is chosen by a pointer register and a context number. It then follows pointer descriptors down through as many as three levels of page tables. Each entry it fetches has a two-bit kind code. The walk can therefore stop early on a large-page leaf at level 1 or level 2, or on a normal 4 KiB leaf at level 3. It stops with a fault code when an entry is invalid or has the wrong kind.

All memory traffic uses one port. The port carries one word at a time, has a single transfer outstanding and uses a valid/ready handshake. Memory holds big-endian words, so the walker swaps bytes on the way in and on the way out. Before it reports a leaf, the walker makes sure the leaf's referenced bit is set, and also its modified bit when the access is a write. If either bit has to change, it writes the updated leaf back to the address it came from. When the enable input is low, the block passes the address straight through. Permission checks, fault registers and translation caching are handled by other blocks.

Top module: `page_walker`

## Requirements
- R1: When `cfgEnable` is low, an accepted request completes with `donePa` equal to the virtual address, `donePte` = 0, `doneLevel` = 0 and `doneFault` = 0, and the memory port makes no transfer.
- R2: The first read of an enabled walk goes to address `(cfgCtxPtr << 4) + (cfgCtx << 4)`, truncated to 32 bits.
- R3: Bits [1:0] of each entry give its kind: 0 invalid, 1 pointer, 2 leaf, 3 reserved. A pointer causes the next read at `({entry[31:2],2'b00} << 4)` plus an index times 4. The index is VA[31:24] when leaving the context table, VA[23:18] when leaving level 1 and VA[17:12] when leaving level 2.
- R4: A leaf found at level L (1, 2 or 3) completes with `doneLevel` = L and `doneFault` = 0. `donePa` is `({leaf[31:8],8'h00} << 4)` truncated to 32 bits, plus the low 24, 18 or 12 bits of the virtual address for L = 1, 2 or 3.
- R5: An invalid entry at any level completes with `doneFault` = 1, `donePa` = 0, `donePte` equal to the fetched entry and `doneLevel` equal to the level where it was found (0 for the context table).
- R6: A reserved entry, a leaf in the context table, or a pointer found at level 3 completes with `doneFault` = 4, `donePa` = 0, `donePte` equal to the entry and `doneLevel` equal to the level where it was found.
- R7: Bit 5 of a leaf is its referenced bit and bit 6 is its modified bit. If bit 5 is clear, or the request is a write and bit 6 is clear, the walker writes the leaf back with bit 5 set (and bit 6 set for a write) to the address it was read from, before it completes. `donePte` shows the updated value. No write happens otherwise.
- R8: Memory words are big-endian. On `memRdata` and `memWdata`, bits [7:0] carry entry bits [31:24], and so on, with bits [31:24] carrying entry bits [7:0].
- R9: While `memValid` is high and `memReady` is low, `memValid`, `memWrite`, `memAddr` and `memWdata` hold their values.
- R10: `reqReady` is high only while the walker is idle, and a request is taken only when `reqValid` and `reqReady` are both high. `doneValid` is a one-cycle pulse that carries every result field together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle and able to take a request |
| reqVa | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | Request is a write access |
| cfgEnable | input | 1 | Translation enabled; when low, addresses pass through |
| cfgCtxPtr | input | 32 | Context table pointer (address >> 4) |
| cfgCtx | input | CTX_W | Current context number |
| memValid | output | 1 | Memory transfer request |
| memReady | input | 1 | Memory accepts the transfer; read data is valid in the same cycle |
| memWrite | output | 1 | Transfer is a write |
| memAddr | output | 32 | Word address of the transfer |
| memWdata | output | 32 | Write data, big-endian byte order |
| memRdata | input | 32 | Read data, big-endian byte order |
| doneValid | output | 1 | One-cycle completion pulse |
| donePa | output | 32 | Physical address |
| donePte | output | 32 | Final entry (leaf after update, or the faulting entry) |
| doneLevel | output | 2 | Level of the final entry, 0 to 3 |
| doneFault | output | 3 | Fault code: 0 none, 1 invalid, 4 bad kind |

## Verification
For a bypass request, `doneValid` rises in the cycle after the accepting edge. For an enabled walk, it rises in the cycle after the last memory handshake. That handshake is the leaf read, or the write-back when one is needed, so the delay depends on how long the memory takes to answer. The bench therefore does not count a fixed number of cycles. It samples at every falling edge until the pulse shows up, with a bound on the wait. It reads all four result fields in that same cycle, and at the next falling edge it checks that the pulse has gone. It logs memory addresses and write data at the falling edge before each accepting clock edge. This lets it compare the order of the table reads and the byte order of the write-back against values worked out from the tables it built.

// File: rtl/walk_pkg.sv
package walk_pkg;

  localparam int WORD_W  = 32;
  localparam int REF_BIT = 5;
  localparam int MOD_BIT = 6;

  typedef enum logic [1:0] {
    ET_INVALID = 2'd0,
    ET_TABLE   = 2'd1,
    ET_LEAF    = 2'd2,
    ET_RSVD    = 2'd3
  } entryKind_t;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_INVALID = 3'd1,
    FLT_BADKIND = 3'd4
  } faultCode_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic       loadReq;
    logic       bypass;
    logic       descend;
    logic       takeLeaf;
    logic       setFault;
    faultCode_t faultCode;
    logic       wbPhase;
  } walkStrobe_t;

endpackage

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        cfgEnable,
  input  logic        memReady,
  input  entryKind_t  entryKind,
  input  logic        needWb,
  input  logic [1:0]  level,
  output logic        reqReady,
  output logic        memValid,
  output logic        memWrite,
  output logic        doneValid,
  output walkStrobe_t stb
);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WBACK, S_DONE} walkState_t;

  localparam logic [1:0] LAST_LEVEL = 2'd3;

  walkState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    stb       = '0;
    nextState = state;
    reqReady  = 1'b0;
    memValid  = 1'b0;
    memWrite  = 1'b0;
    doneValid = 1'b0;
    unique case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.loadReq = 1'b1;
          if (!cfgEnable) begin
            stb.bypass = 1'b1;
            nextState  = S_DONE;
          end else begin
            nextState = S_FETCH;
          end
        end
      end
      S_FETCH: begin
        memValid = 1'b1;
        if (memReady) begin
          unique case (entryKind)
            ET_INVALID: begin
              stb.setFault  = 1'b1;
              stb.faultCode = FLT_INVALID;
              nextState     = S_DONE;
            end
            ET_RSVD: begin
              stb.setFault  = 1'b1;
              stb.faultCode = FLT_BADKIND;
              nextState     = S_DONE;
            end
            ET_LEAF: begin
              if (level == 2'd0) begin
                stb.setFault  = 1'b1;
                stb.faultCode = FLT_BADKIND;
                nextState     = S_DONE;
              end else begin
                stb.takeLeaf = 1'b1;
                nextState    = needWb ? S_WBACK : S_DONE;
              end
            end
            ET_TABLE: begin
              if (level == LAST_LEVEL) begin
                stb.setFault  = 1'b1;
                stb.faultCode = FLT_BADKIND;
                nextState     = S_DONE;
              end else begin
                stb.descend = 1'b1;
              end
            end
          endcase
        end
      end
      S_WBACK: begin
        memValid    = 1'b1;
        memWrite    = 1'b1;
        stb.wbPhase = 1'b1;
        if (memReady) nextState = S_DONE;
      end
      S_DONE: begin
        doneValid = 1'b1;
        nextState = S_IDLE;
      end
    endcase
  end

  // R10: completion lasts exactly one cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |=> !doneValid);

  // R10: no request taken while a result is being reported
  a_r10_busy_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |-> !reqReady);

  // R1: a pass-through request completes next cycle without a transfer
  a_r1_bypass_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady && !cfgEnable) |=> (doneValid && !memValid));

  // R9: a pending transfer is not withdrawn or changed in direction
  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (memValid && !memReady) |=> (memValid && $stable(memWrite)));

endmodule

// File: rtl/walk_dp.sv
module walk_dp
  import walk_pkg::*;
#(
  parameter int PAGE_BITS  = 12,
  parameter int L3_BITS    = 6,
  parameter int L2_BITS    = 6,
  parameter int CTX_W      = 8,
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  walkStrobe_t       stb,
  input  logic [WORD_W-1:0] reqVa,
  input  logic              reqWrite,
  input  logic [WORD_W-1:0] cfgCtxPtr,
  input  logic [CTX_W-1:0]  cfgCtx,
  input  logic [WORD_W-1:0] memRdata,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output entryKind_t        entryKind,
  output logic              needWb,
  output logic [1:0]        level,
  output logic [WORD_W-1:0] donePa,
  output logic [WORD_W-1:0] donePte,
  output logic [1:0]        doneLevel,
  output faultCode_t        doneFault
);

  localparam int OFF3 = PAGE_BITS;
  localparam int OFF2 = OFF3 + L3_BITS;
  localparam int OFF1 = OFF2 + L2_BITS;
  localparam logic [WORD_W-1:0] MASK1 = (WORD_W'(1) << OFF1) - WORD_W'(1);
  localparam logic [WORD_W-1:0] MASK2 = (WORD_W'(1) << OFF2) - WORD_W'(1);
  localparam logic [WORD_W-1:0] MASK3 = (WORD_W'(1) << OFF3) - WORD_W'(1);

  logic [WORD_W-1:0] vaReg, addrReg, paReg, pteReg;
  logic              writeReg;
  logic [1:0]        levelReg;
  faultCode_t        faultReg;

  logic [WORD_W-1:0] entry;
  logic [WORD_W-1:0] ctxAddr, nextBase, nextIdx, leafBase, leafOff, leafPa, markedLeaf;

  // Byte order between the memory port and the entry value
  generate
    if (BIG_ENDIAN) begin : g_swap
      assign entry    = {memRdata[7:0], memRdata[15:8], memRdata[23:16], memRdata[31:24]};
      assign memWdata = {pteReg[7:0], pteReg[15:8], pteReg[23:16], pteReg[31:24]};
    end else begin : g_direct
      assign entry    = memRdata;
      assign memWdata = pteReg;
    end
  endgenerate

  assign entryKind = entryKind_t'(entry[1:0]);
  assign needWb    = !entry[REF_BIT] || (writeReg && !entry[MOD_BIT]);

  assign ctxAddr  = (cfgCtxPtr << 4) + (WORD_W'(cfgCtx) << 4);
  assign nextBase = {entry[WORD_W-1:2], 2'b00} << 4;
  assign leafBase = {entry[WORD_W-1:8], 8'h00} << 4;

  always_comb begin
    unique case (levelReg)
      2'd0:    nextIdx = WORD_W'(vaReg[WORD_W-1:OFF1]) << 2;
      2'd1:    nextIdx = WORD_W'(vaReg[OFF1-1:OFF2]) << 2;
      default: nextIdx = WORD_W'(vaReg[OFF2-1:OFF3]) << 2;
    endcase
    unique case (levelReg)
      2'd1:    leafOff = vaReg & MASK1;
      2'd2:    leafOff = vaReg & MASK2;
      default: leafOff = vaReg & MASK3;
    endcase
  end

  assign leafPa     = leafBase + leafOff;
  assign markedLeaf = entry | (WORD_W'(1) << REF_BIT) | (WORD_W'(writeReg) << MOD_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vaReg    <= '0;
      writeReg <= 1'b0;
      addrReg  <= '0;
      levelReg <= 2'd0;
      paReg    <= '0;
      pteReg   <= '0;
      faultReg <= FLT_NONE;
    end else begin
      if (stb.loadReq) begin
        vaReg    <= reqVa;
        writeReg <= reqWrite;
        addrReg  <= ctxAddr;
        levelReg <= 2'd0;
        paReg    <= '0;
        pteReg   <= '0;
        faultReg <= FLT_NONE;
      end
      if (stb.bypass) paReg <= reqVa;
      if (stb.descend) begin
        addrReg  <= nextBase + nextIdx;
        levelReg <= levelReg + 2'd1;
      end
      if (stb.takeLeaf) begin
        paReg  <= leafPa;
        pteReg <= markedLeaf;
      end
      if (stb.setFault) begin
        faultReg <= stb.faultCode;
        paReg    <= '0;
        pteReg   <= entry;
      end
    end
  end

  assign memAddr   = addrReg;
  assign level     = levelReg;
  assign donePa    = paReg;
  assign donePte   = pteReg;
  assign doneLevel = levelReg;
  assign doneFault = faultReg;

  // R7: a write-back always carries the bits the access needs
  a_r7_wb_marked: assert property (@(posedge clk) disable iff (!rst_n)
    stb.wbPhase |-> (pteReg[REF_BIT] && (!writeReg || pteReg[MOD_BIT])));

  // R3: the walk never goes deeper than level 3
  a_r3_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    stb.descend |-> (levelReg != 2'd3));

endmodule

// File: rtl/page_walker.sv
module page_walker
  import walk_pkg::*;
#(
  parameter int PAGE_BITS  = 12,
  parameter int L3_BITS    = 6,
  parameter int L2_BITS    = 6,
  parameter int CTX_W      = 8,
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [31:0]      reqVa,
  input  logic             reqWrite,
  input  logic             cfgEnable,
  input  logic [31:0]      cfgCtxPtr,
  input  logic [CTX_W-1:0] cfgCtx,
  output logic             memValid,
  input  logic             memReady,
  output logic             memWrite,
  output logic [31:0]      memAddr,
  output logic [31:0]      memWdata,
  input  logic [31:0]      memRdata,
  output logic             doneValid,
  output logic [31:0]      donePa,
  output logic [31:0]      donePte,
  output logic [1:0]       doneLevel,
  output logic [2:0]       doneFault
);

  walkStrobe_t stb;
  entryKind_t  entryKind;
  faultCode_t  faultOut;
  logic        needWb;
  logic [1:0]  level;

  walk_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reqValid  (reqValid),
    .cfgEnable (cfgEnable),
    .memReady  (memReady),
    .entryKind (entryKind),
    .needWb    (needWb),
    .level     (level),
    .reqReady  (reqReady),
    .memValid  (memValid),
    .memWrite  (memWrite),
    .doneValid (doneValid),
    .stb       (stb)
  );

  walk_dp #(
    .PAGE_BITS  (PAGE_BITS),
    .L3_BITS    (L3_BITS),
    .L2_BITS    (L2_BITS),
    .CTX_W      (CTX_W),
    .BIG_ENDIAN (BIG_ENDIAN)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .reqVa     (reqVa),
    .reqWrite  (reqWrite),
    .cfgCtxPtr (cfgCtxPtr),
    .cfgCtx    (cfgCtx),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .entryKind (entryKind),
    .needWb    (needWb),
    .level     (level),
    .donePa    (donePa),
    .donePte   (donePte),
    .doneLevel (doneLevel),
    .doneFault (faultOut)
  );

  assign doneFault = faultOut;

  // R9: address and write data stay put until the transfer is taken
  a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (memValid && !memReady) |=> ($stable(memAddr) && $stable(memWdata)));

  // R2: an enabled walk opens with a read of the context entry
  a_r2_ctx_first: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady && cfgEnable) |=>
      (memValid && !memWrite &&
       memAddr == (($past(cfgCtxPtr) << 4) + (32'($past(cfgCtx)) << 4))));

  // R5, R6: only the three defined fault codes ever appear
  a_r5_fault_codes: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |-> (doneFault == 3'd0 || doneFault == 3'd1 || doneFault == 3'd4));

endmodule

// File: tb/page_walker_test.sv
module page_walker_test;

  localparam int CTX_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reqValid = 1'b0;
  logic             reqReady;
  logic [31:0]      reqVa = '0;
  logic             reqWrite = 1'b0;
  logic             cfgEnable = 1'b0;
  logic [31:0]      cfgCtxPtr = '0;
  logic [CTX_W-1:0] cfgCtx = '0;
  logic             memValid;
  logic             memReady = 1'b0;
  logic             memWrite;
  logic [31:0]      memAddr;
  logic [31:0]      memWdata;
  logic [31:0]      memRdata = '0;
  logic             doneValid;
  logic [31:0]      donePa;
  logic [31:0]      donePte;
  logic [1:0]       doneLevel;
  logic [2:0]       doneFault;

  page_walker #(.CTX_W(CTX_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .reqReady(reqReady), .reqVa(reqVa), .reqWrite(reqWrite),
    .cfgEnable(cfgEnable), .cfgCtxPtr(cfgCtxPtr), .cfgCtx(cfgCtx),
    .memValid(memValid), .memReady(memReady), .memWrite(memWrite),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .doneValid(doneValid), .donePa(donePa), .donePte(donePte),
    .doneLevel(doneLevel), .doneFault(doneFault)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  logic [31:0] memModel [logic [31:0]];
  logic [31:0] readLog [8];
  int          readCnt = 0;
  int          wrCount = 0;
  logic [31:0] lastWrAddr = '0;
  logic [31:0] lastWrRaw = '0;
  int          holdViol = 0;
  bit          pending = 1'b0;
  logic [31:0] pendAddr = '0;
  logic [31:0] pendData = '0;
  bit          pendWr = 1'b0;

  function automatic logic [31:0] bsw(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [31:0] memGet(input logic [31:0] a);
    if (memModel.exists(a)) return memModel[a];
    return 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Memory responder: decides ready and data at the falling edge
  always @(negedge clk) begin
    bit rdy;
    if (memValid && pending &&
        (memAddr != pendAddr || memWrite != pendWr || memWdata != pendData))
      holdViol++;
    rdy = ($urandom % 4) != 0;
    memReady = rdy;
    memRdata = bsw(memGet(memAddr));
    if (memValid && rdy) begin
      pending = 1'b0;
      if (memWrite) begin
        memModel[memAddr] = bsw(memWdata);
        wrCount++;
        lastWrAddr = memAddr;
        lastWrRaw  = memWdata;
      end else begin
        if (readCnt < 8) readLog[readCnt] = memAddr;
        readCnt++;
      end
    end else begin
      pending  = memValid;
      pendAddr = memAddr;
      pendData = memWdata;
      pendWr   = memWrite;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      failures++;
      $display("FAIL R10 watchdog actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Independent model of the walk, from the requirements
  function automatic void refWalk(input logic [31:0] va, input bit wr,
      output logic [31:0] pa, output logic [31:0] pte, output logic [1:0] lvl,
      output logic [2:0] flt, output bit wb, output logic [31:0] wbA,
      output logic [31:0] wbD);
    logic [31:0] addr, e, newE, idx;
    int ob;
    pa = '0; pte = '0; lvl = '0; flt = '0; wb = 1'b0; wbA = '0; wbD = '0;
    if (!cfgEnable) begin
      pa = va;
      return;
    end
    addr = (cfgCtxPtr << 4) + (32'(cfgCtx) << 4);
    for (int l = 0; l < 4; l++) begin
      e = memGet(addr);
      lvl = 2'(l);
      case (e[1:0])
        2'd0: begin flt = 3'd1; pte = e; return; end
        2'd3: begin flt = 3'd4; pte = e; return; end
        2'd2: begin
          if (l == 0) begin flt = 3'd4; pte = e; return; end
          ob = (l == 1) ? 24 : (l == 2) ? 18 : 12;
          pa = ({e[31:8], 8'h00} << 4) + (va & ((32'h1 << ob) - 32'h1));
          newE = e | 32'h20 | (wr ? 32'h40 : 32'h0);
          wb = (newE != e);
          pte = newE; wbA = addr; wbD = newE;
          return;
        end
        default: begin
          if (l == 3) begin flt = 3'd4; pte = e; return; end
          idx = (l == 0) ? 32'(va[31:24]) : (l == 1) ? 32'(va[23:18]) : 32'(va[17:12]);
          addr = ({e[31:2], 2'b00} << 4) + (idx << 2);
        end
      endcase
    end
  endfunction

  task automatic waitDone(output bit got);
    int n = 0;
    got = 1'b0;
    while (!doneValid && n < 1000) begin
      @(negedge clk);
      n++;
    end
    got = doneValid;
    if (!got) chk(1'b0, "R10", "no completion", 64'(n), 64'd1000);
  endtask

  task automatic doWalk(input logic [31:0] va, input bit wr, input string what);
    logic [31:0] ePa, ePte, eWbA, eWbD;
    logic [1:0]  eL;
    logic [2:0]  eF;
    bit          eWb, got;
    string       tag;
    refWalk(va, wr, ePa, ePte, eL, eF, eWb, eWbA, eWbD);
    tag = !cfgEnable ? "R1" : (eF == 3'd1) ? "R5" : (eF == 3'd4) ? "R6" : "R4";
    readCnt = 0;
    wrCount = 0;
    @(negedge clk);
    reqValid = 1'b1; reqVa = va; reqWrite = wr;
    @(negedge clk);
    reqValid = 1'b0;
    waitDone(got);
    if (got) begin
      chk(donePa == ePa, tag, what, 64'(donePa), 64'(ePa));
      chk(donePte == ePte, eWb ? "R7" : tag, what, 64'(donePte), 64'(ePte));
      chk({doneLevel, doneFault} == {eL, eF}, tag, what,
          64'({doneLevel, doneFault}), 64'({eL, eF}));
      if (!cfgEnable)
        chk(readCnt + wrCount == 0, "R1", "bypass transfers", 64'(readCnt + wrCount), 64'd0);
      else if (eF == 3'd0) begin
        chk(wrCount == (eWb ? 1 : 0), "R7", "write-back count", 64'(wrCount), 64'(eWb));
        if (eWb) begin
          chk(lastWrAddr == eWbA, "R7", "write-back address", 64'(lastWrAddr), 64'(eWbA));
          chk(lastWrRaw == bsw(eWbD), "R8", "write-back bytes", 64'(lastWrRaw), 64'(bsw(eWbD)));
        end
      end
      @(negedge clk);
      chk(!doneValid, "R10", "done pulse width", 64'(doneValid), 64'd0);
    end
  endtask

  // Builds a three-level path for va; ctx table at 0x1000
  task automatic buildPath(input logic [31:0] va, input int depth, input logic [31:0] term);
    logic [31:0] addr;
    logic [31:0] bases [3];
    bases[0] = 32'h4000; bases[1] = 32'h8000; bases[2] = 32'hA000;
    addr = (cfgCtxPtr << 4) + (32'(cfgCtx) << 4);
    for (int l = 0; l < depth; l++) begin
      memModel[addr] = (bases[l] >> 4) | 32'h1;
      addr = bases[l] + (((l == 0) ? 32'(va[31:24]) : (l == 1) ? 32'(va[23:18]) : 32'(va[17:12])) << 2);
    end
    memModel[addr] = term;
  endtask

  initial begin
    bit got;
    int extra;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R10", "reset ready", 64'(reqReady), 64'd1);
    chk(doneValid == 1'b0, "R10", "reset done", 64'(doneValid), 64'd0);
    chk(memValid == 1'b0, "R9", "reset memValid", 64'(memValid), 64'd0);

    // Pass-through
    cfgEnable = 1'b0;
    doWalk(32'hDEADBEEF, 1'b1, "bypass");

    // Full three-level walk with directed addresses
    cfgEnable = 1'b1; cfgCtxPtr = 32'h100; cfgCtx = 8'd3;
    buildPath(32'h12345678, 3, 32'h00ABCD62);
    doWalk(32'h12345678, 1'b0, "level3 leaf");
    chk(readCnt == 4, "R3", "read count", 64'(readCnt), 64'd4);
    chk(readLog[0] == 32'h1030, "R2", "ctx address", 64'(readLog[0]), 64'h1030);
    chk(readLog[1] == 32'h4048, "R3", "level1 address", 64'(readLog[1]), 64'h4048);
    chk(readLog[2] == 32'h8034, "R3", "level2 address", 64'(readLog[2]), 64'h8034);
    chk(readLog[3] == 32'hA014, "R3", "level3 address", 64'(readLog[3]), 64'hA014);
    chk(donePa == 32'h0ABCD678, "R4", "level3 pa", 64'(donePa), 64'h0ABCD678);
    chk(donePte == 32'h00ABCD62, "R8", "entry byte order", 64'(donePte), 64'h00ABCD62);

    // Write with modified clear, then read with referenced clear
    buildPath(32'h12345678, 3, 32'h00ABCD22);
    doWalk(32'h12345678, 1'b1, "write sets modified");
    chk(memGet(32'hA014) == 32'h00ABCD62, "R7", "stored leaf", 64'(memGet(32'hA014)), 64'h00ABCD62);
    buildPath(32'h12345678, 3, 32'h00ABCD02);
    doWalk(32'h12345678, 1'b0, "read sets referenced");
    chk(memGet(32'hA014) == 32'h00ABCD22, "R7", "stored leaf", 64'(memGet(32'hA014)), 64'h00ABCD22);

    // Large pages
    buildPath(32'h5A123456, 1, 32'hFEDCBA62);
    doWalk(32'h5A123456, 1'b0, "level1 leaf");
    buildPath(32'h5A9C3456, 2, 32'h13579B62);
    doWalk(32'h5A9C3456, 1'b1, "level2 leaf");

    // Faults
    buildPath(32'h00000000, 0, 32'h11112222);
    doWalk(32'h00000000, 1'b0, "leaf in ctx table");
    buildPath(32'h77700000, 3, 32'h00000A01);
    doWalk(32'h77700000, 1'b0, "pointer at level3");
    buildPath(32'h77700000, 2, 32'hCAFE0000);
    doWalk(32'h77700000, 1'b0, "invalid at level2");
    buildPath(32'h77700000, 1, 32'hCAFE0003);
    doWalk(32'h77700000, 1'b0, "reserved at level1");

    // Request while busy is not taken
    buildPath(32'h12345678, 3, 32'h00ABCD62);
    readCnt = 0; wrCount = 0;
    @(negedge clk);
    reqValid = 1'b1; reqVa = 32'h12345678; reqWrite = 1'b0;
    @(negedge clk);
    reqVa = 32'h00000000;
    @(negedge clk);
    chk(reqReady == 1'b0, "R10", "busy ready", 64'(reqReady), 64'd0);
    @(negedge clk);
    reqValid = 1'b0;
    waitDone(got);
    if (got) chk(donePa == 32'h0ABCD678, "R10", "busy poke result", 64'(donePa), 64'h0ABCD678);
    extra = 0;
    repeat (12) begin
      @(negedge clk);
      if (doneValid) extra++;
    end
    chk(extra == 0, "R10", "extra completions", 64'(extra), 64'd0);

    // Random walks
    for (int it = 0; it < 80; it++) begin
      logic [31:0] va, term;
      int kind;
      cfgEnable = ($urandom % 10) != 0;
      cfgCtx = 8'($urandom % 16);
      va = $urandom;
      kind = $urandom % 20;
      term = $urandom;
      term[1:0] = (kind < 10) ? 2'd2 : (kind < 14) ? 2'd0 : (kind < 17) ? 2'd3 : 2'd1;
      buildPath(va, int'($urandom % 4), term);
      doWalk(va, 1'($urandom), "random");
    end

    chk(holdViol == 0, "R9", "transfer hold", 64'(holdViol), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule